// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of the configuration path of a stereo audio converter. A host microcontroller uses it to load and read back a small bank of 8-bit settings registers. Those registers drive the rest of the converter. After reset the port assumes the two-wire control protocol is in use, which is handled elsewhere. While in that state the select, clock and data pins have no effect on the bank. The first high-to-low transition of the chip-select pin switches the port permanently to four-wire SPI operation. It stays in SPI operation until the next reset.

In SPI operation every transaction opens with a device byte: a fixed 7-bit chip address followed by a direction flag. A write then carries a pointer byte and any number of data bytes. A read returns the pointed register, followed by its successors for as long as the select stays low and the clock keeps running. The pointer steps forward after every data byte and wraps around inside the register window. All three serial pins are oversampled in the system clock domain. The serial output comes with an enable, so an external pad can float the line whenever read data is not being shifted.

Top module: `codec_ctl_port`

## Requirements
- R1: While `rst_n` is low and after it is released, the bank holds 01h=72h, 02h=00h, 03h=09h, 04h=C0h, 05h=00h, 06h=00h, 07h=B0h, 08h=40h, 09h=00h. `spi_mode` is 0 and `sdo_oe` is 0. The register at address A appears on `regs[(A-1)*8 +: 8]`.
- R2: Until the first falling edge of `cs_n`, activity on `sclk` and `sdi` changes no register and does not set `spi_mode`.
- R3: A falling edge of `cs_n` sets `spi_mode` to 1. It stays 1 until `rst_n` goes low.
- R4: `sdi` is sampled on rising `sclk` edges while `cs_n` is low, MSB first. The first byte must be 1001100 followed by a flag bit: 98h means write and 99h means read. Any other first byte makes the port ignore the rest of the transaction.
- R5: In a write, the second byte loads the pointer. Each later byte is stored at the pointer, and the pointer then advances. Address 09h is followed by 01h.
- R6: Address 01h is a read-only identity register holding 72h. Data bytes aimed at it are dropped, but they still advance the pointer.
- R7: In a read, the register at the pointer is shifted out MSB first, with each bit changing after a falling `sclk` edge. The pointer then advances, using the same wrap as R5, for every further byte clocked while `cs_n` stays low.
- R8: `sdo_oe` is 1 only while a read is shifting data, from the first falling `sclk` edge after a valid read device byte onward. It is 0 during the device byte, in writes and ignored transactions, and once `cs_n` is high.
- R9: A pointer outside 01h..09h reads as 00h, and writes through it change nothing.
- R10: Raising `cs_n` ends the transaction at any point, including mid-byte. The next transaction starts again with a device byte, aligned to its first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial control clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo`; pad floats when 0 |
| spi_mode | output | 1 | 1 once the port has switched to SPI operation |
| regs | output | 72 | Register bank, address 01h in the low byte |

## Verification
Each serial pin passes through a two-stage synchronizer and one edge-detect register. A read bit therefore appears on `sdo` about three system cycles after the falling `sclk` edge. A written byte reaches `regs` about four cycles after the eighth rising edge. The bench holds each half of the `sclk` period for eight system cycles and samples `sdo` and `sdo_oe` at the end of the low half, when the bit has long settled. Register contents are compared twelve cycles after `cs_n` rises, which is well after every pending write has landed.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

   // fixed 7-bit device address carried by the first byte of a transaction
   localparam logic [6:0] CCP_DEV_ID = 7'b1001100;

   typedef logic [7:0] ccp_byte_t;

   // byte phase inside one select-low window
   typedef enum logic [2:0] {
      PH_DEVICE,
      PH_POINTER,
      PH_WRITE,
      PH_READ,
      PH_SKIP
   } ccp_phase_e;

endpackage

// File: rtl/ccp_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
module ccp_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ccp_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ccp_sync: WIDTH must be at least 1");
   end

   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) begin
            stg[s] <= RST_VAL;
         end
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[LAST];

endmodule

// File: rtl/ccp_shifter.sv
// Bit engine: serial capture on rising sclk, serial launch on falling sclk.
module ccp_shifter
   import ccp_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sclk_lvl,
   input  logic              sdi_lvl,
   input  logic              load_en,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              tx_enable,
   output logic              sclk_fall,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              tx_bit
);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("ccp_shifter: BYTE_W must be at least 2");
   end

   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   logic              sclk_prev;
   logic              sclk_rise;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;

   assign sclk_rise = sclk_lvl & ~sclk_prev;
   assign sclk_fall = ~sclk_lvl & sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
      end else begin
         sclk_prev <= sclk_lvl;
      end
   end

   // capture side: framing restarts whenever the window closes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         byte_done <= 1'b0;
      end else if (!active) begin
         bit_cnt   <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sclk_rise) begin
            rx_sh     <= {rx_sh[BYTE_W-2:0], sdi_lvl};
            bit_cnt   <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
            byte_done <= (bit_cnt == CNT_LAST);
         end
      end
   end

   assign rx_byte = rx_sh;

   // launch side: MSB first, advancing on each falling sclk edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         tx_bit <= 1'b0;
      end else if (load_en) begin
         tx_sh <= load_byte;
      end else if (active && tx_enable && sclk_fall) begin
         tx_bit <= tx_sh[BYTE_W-1];
         tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/ccp_regbank.sv
// Configuration register storage with a read-only identity slot.
module ccp_regbank #(
   parameter int               NREG       = 9,
   parameter int               FIRST_ADDR = 1,
   parameter int               ID_ADDR    = 1,
   parameter logic [NREG*8-1:0] DEFAULTS  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        rd_addr,
   output logic [7:0]        rd_data,
   output logic [NREG*8-1:0] regs
);

   if (NREG < 1 || FIRST_ADDR + NREG > 256) begin : g_bad_window
      $error("ccp_regbank: register window does not fit an 8-bit pointer");
   end

   logic [7:0] store [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [7:0] ADDR = 8'(FIRST_ADDR + i);
      localparam logic [7:0] DEF  = DEFAULTS[i*8 +: 8];
      logic [7:0] q;

      if (FIRST_ADDR + i == ID_ADDR) begin : g_ro
         assign q = DEF;
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= DEF;
            end else if (wr_en && (wr_addr == ADDR)) begin
               q <= wr_data;
            end
         end
      end

      assign store[i]       = q;
      assign regs[i*8 +: 8] = q;
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NREG; i++) begin
         if (rd_addr == 8'(FIRST_ADDR + i)) begin
            rd_data = store[i];
         end
      end
   end

endmodule

// File: rtl/ccp_ctrl.sv
// Mode latch, byte-phase sequencer and register pointer.
module ccp_ctrl
   import ccp_pkg::*;
#(
   parameter int         NREG       = 9,
   parameter int         FIRST_ADDR = 1,
   parameter logic [6:0] DEV_ID     = CCP_DEV_ID
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_lvl,
   input  logic       sclk_fall,
   input  logic       byte_done,
   input  logic [7:0] rx_byte,
   output logic       active,
   output logic       spi_mode,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] rd_addr,
   output logic       load_en,
   output logic       tx_enable,
   output logic       drive
);

   localparam logic [7:0] P_FIRST = 8'(FIRST_ADDR);
   localparam logic [7:0] P_LAST  = 8'(FIRST_ADDR + NREG - 1);

   ccp_phase_e phase;
   logic       cs_prev;
   logic       cs_fall;
   logic       mode_q;
   logic       load_req;
   logic       drive_q;
   logic [7:0] ptr;

   function automatic logic [7:0] ptr_next(input logic [7:0] p);
      if (p < P_FIRST || p >= P_LAST) begin
         return P_FIRST;
      end
      return p + 8'd1;
   endfunction

   assign cs_fall = cs_prev & ~cs_lvl;
   assign active  = mode_q & ~cs_lvl;

   // mode latch: set by the first select falling edge, cleared only by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev <= 1'b1;
         mode_q  <= 1'b0;
      end else begin
         cs_prev <= cs_lvl;
         if (cs_fall) begin
            mode_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_DEVICE;
         ptr      <= P_FIRST;
         load_req <= 1'b0;
         drive_q  <= 1'b0;
      end else if (!active) begin
         phase    <= PH_DEVICE;
         load_req <= 1'b0;
         drive_q  <= 1'b0;
      end else begin
         load_req <= 1'b0;
         if (load_req) begin
            ptr <= ptr_next(ptr);
         end
         if (sclk_fall && phase == PH_READ) begin
            drive_q <= 1'b1;
         end
         if (byte_done) begin
            unique case (phase)
               PH_DEVICE: begin
                  if (rx_byte[7:1] != DEV_ID) begin
                     phase <= PH_SKIP;
                  end else if (rx_byte[0]) begin
                     phase    <= PH_READ;
                     load_req <= 1'b1;
                  end else begin
                     phase <= PH_POINTER;
                  end
               end
               PH_POINTER: begin
                  ptr   <= rx_byte;
                  phase <= PH_WRITE;
               end
               PH_WRITE: begin
                  ptr <= ptr_next(ptr);
               end
               PH_READ: begin
                  load_req <= 1'b1;
               end
               PH_SKIP: begin
                  phase <= PH_SKIP;
               end
               default: begin
                  phase <= PH_SKIP;
               end
            endcase
         end
      end
   end

   assign spi_mode  = mode_q;
   assign wr_en     = active & byte_done & (phase == PH_WRITE);
   assign wr_addr   = ptr;
   assign wr_data   = rx_byte;
   assign rd_addr   = ptr;
   assign load_en   = load_req;
   assign tx_enable = (phase == PH_READ);
   assign drive     = drive_q & active;

endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port
   import ccp_pkg::*;
#(
   parameter int               NREG        = 9,
   parameter int               FIRST_ADDR  = 1,
   parameter int               ID_ADDR     = 1,
   parameter int               SYNC_STAGES = 2,
   parameter logic [6:0]       DEV_ID      = CCP_DEV_ID,
   parameter logic [NREG*8-1:0] DEFAULTS   = 72'h00_40_B0_00_00_C0_09_00_72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              spi_mode,
   output logic [NREG*8-1:0] regs
);

   if (ID_ADDR < FIRST_ADDR || ID_ADDR >= FIRST_ADDR + NREG) begin : g_bad_id
      $error("codec_ctl_port: ID_ADDR lies outside the register window");
   end
   if (FIRST_ADDR < 1) begin : g_bad_first
      $error("codec_ctl_port: FIRST_ADDR must be at least 1");
   end

   localparam int          PIN_W   = 3;
   localparam logic [2:0]  PIN_RST = 3'b100;

   logic [PIN_W-1:0] pin_q;
   logic             cs_lvl;
   logic             sclk_lvl;
   logic             sdi_lvl;

   logic       active;
   logic       sclk_fall;
   logic       byte_done;
   logic [7:0] rx_byte;
   logic       tx_bit;
   logic       wr_en;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   logic [7:0] rd_addr;
   logic [7:0] rd_data;
   logic       load_en;
   logic       tx_enable;
   logic       drive;

   ccp_sync #(
      .WIDTH   (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     (pin_q)
   );

   assign cs_lvl   = pin_q[2];
   assign sclk_lvl = pin_q[1];
   assign sdi_lvl  = pin_q[0];

   ccp_ctrl #(
      .NREG       (NREG),
      .FIRST_ADDR (FIRST_ADDR),
      .DEV_ID     (DEV_ID)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_lvl    (cs_lvl),
      .sclk_fall (sclk_fall),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .active    (active),
      .spi_mode  (spi_mode),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .load_en   (load_en),
      .tx_enable (tx_enable),
      .drive     (drive)
   );

   ccp_shifter #(
      .BYTE_W (8)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .sclk_lvl  (sclk_lvl),
      .sdi_lvl   (sdi_lvl),
      .load_en   (load_en),
      .load_byte (rd_data),
      .tx_enable (tx_enable),
      .sclk_fall (sclk_fall),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .tx_bit    (tx_bit)
   );

   ccp_regbank #(
      .NREG       (NREG),
      .FIRST_ADDR (FIRST_ADDR),
      .ID_ADDR    (ID_ADDR),
      .DEFAULTS   (DEFAULTS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .regs    (regs)
   );

   assign sdo    = tx_bit;
   assign sdo_oe = drive;

endmodule

// File: rtl/ccp_chk.sv
module ccp_chk #(
   parameter int NREG = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sdo_oe,
   input logic              spi_mode,
   input logic [NREG*8-1:0] regs
);

   // R3
   spi_mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_mode |=> spi_mode);

   // R8
   oe_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> spi_mode);

   // R8
   oe_off_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

   // R2
   idle_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_mode |=> $stable(regs));

endmodule

bind codec_ctl_port ccp_chk #(.NREG(NREG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .sdo_oe   (sdo_oe),
   .spi_mode (spi_mode),
   .regs     (regs)
);

// File: tb/codec_ctl_port_test.sv
module codec_ctl_port_test;

   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo;
   logic       sdo_oe;
   logic       spi_mode;
   logic [71:0] regs;

   int checks = 0;
   int errors = 0;
   int oe_bad = 0;
   bit done = 0;

   logic [7:0] txb [8];
   logic [7:0] rxb [8];
   logic [7:0] exp_r [1:9];

   // R1 reset contents, index = address
   localparam logic [7:0] DEF_V [1:9] = '{8'h72, 8'h00, 8'h09, 8'hC0, 8'h00,
                                         8'h00, 8'hB0, 8'h40, 8'h00};

   // {pointer, data written, value expected on read back}
   localparam logic [23:0] VEC [6] = '{
      24'h02_5A_5A, 24'h05_A3_A3, 24'h09_FF_FF,
      24'h01_55_72, 24'h0C_77_00, 24'h03_00_00};

   codec_ctl_port uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe),
      .spi_mode (spi_mode),
      .regs     (regs)
   );

   always #5 clk = ~clk;

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] nxt(input logic [7:0] p);
      return (p < 8'h01 || p >= 8'h09) ? 8'h01 : p + 8'h01;
   endfunction

   task automatic check_bank(input string req);
      for (int a = 1; a <= 9; a++) begin
         check(req, {24'h0, regs[(a-1)*8 +: 8]}, {24'h0, exp_r[a]});
      end
   endtask

   // one select-low window of n bytes; expect_oe: data bytes must be driven
   task automatic xfer(input int n, input bit expect_oe);
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            sdi = txb[i][b];
            wait_clk(HALF);
            rxb[i][b] = sdo;
            if (sdo_oe !== ((i > 0) && expect_oe)) oe_bad++;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
         end
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(12);
   endtask

   // mirror a write window in the bench model
   task automatic model_write(input int n);
      logic [7:0] p;
      p = txb[1];
      for (int i = 2; i < n; i++) begin
         if (p >= 8'h02 && p <= 8'h09) exp_r[p] = txb[i];
         p = nxt(p);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int a = 1; a <= 9; a++) exp_r[a] = DEF_V[a];
      wait_clk(4);
      // R1 state held in reset
      check("R1", {31'h0, spi_mode}, 32'h0);
      check("R1", {31'h0, sdo_oe}, 32'h0);
      rst_n = 1'b1;
      wait_clk(4);
      check_bank("R1");

      // R2: clock and data toggles with select high
      for (int k = 0; k < 20; k++) begin
         sdi = k[0];
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
         wait_clk(HALF);
      end
      check("R2", {31'h0, spi_mode}, 32'h0);
      check_bank("R2");

      // table walk: write, then point and read back (R4 R5 R6 R7 R9)
      for (int v = 0; v < 6; v++) begin
         txb[0] = 8'h98; txb[1] = VEC[v][23:16]; txb[2] = VEC[v][15:8];
         xfer(3, 1'b0);
         model_write(3);
         if (v == 0) check("R3", {31'h0, spi_mode}, 32'h1);
         txb[0] = 8'h98; txb[1] = VEC[v][23:16];
         xfer(2, 1'b0);
         txb[0] = 8'h99; txb[1] = 8'h00;
         oe_bad = 0;
         xfer(2, 1'b1);
         check("R7", {24'h0, rxb[1]}, {24'h0, VEC[v][7:0]});
         check("R8", oe_bad, 0);
      end
      check_bank("R5");

      // R4: wrong device address on a write
      txb[0] = 8'h9A; txb[1] = 8'h02; txb[2] = 8'h11;
      oe_bad = 0;
      xfer(3, 1'b0);
      check_bank("R4");
      check("R8", oe_bad, 0);
      // R4 R8: wrong device address on a read leaves output floating
      txb[0] = 8'h9B; txb[1] = 8'h00;
      oe_bad = 0;
      xfer(2, 1'b0);
      check("R8", oe_bad, 0);

      // R5 R6: burst write from 08h wraps past 09h through 01h to 02h
      txb[0] = 8'h98; txb[1] = 8'h08;
      txb[2] = 8'h01; txb[3] = 8'h02; txb[4] = 8'h03; txb[5] = 8'h04;
      xfer(6, 1'b0);
      model_write(6);
      check("R6", {24'h0, regs[7:0]}, 32'h72);
      check("R5", {24'h0, regs[15:8]}, 32'h04);
      check_bank("R5");

      // R7: burst read from 08h, MSB first, with wrap
      txb[0] = 8'h98; txb[1] = 8'h08;
      xfer(2, 1'b0);
      txb[0] = 8'h99; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00; txb[4] = 8'h00;
      oe_bad = 0;
      xfer(5, 1'b1);
      check("R7", {24'h0, rxb[1]}, {24'h0, exp_r[8]});
      check("R7", {24'h0, rxb[2]}, {24'h0, exp_r[9]});
      check("R7", {24'h0, rxb[3]}, 32'h72);
      check("R7", {24'h0, rxb[4]}, {24'h0, exp_r[2]});
      check("R8", oe_bad, 0);
      check("R8", {31'h0, sdo_oe}, 32'h0);

      // R10: aborted half byte, then a clean write
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int b = 0; b < 4; b++) begin
         sdi = 1'b1;
         wait_clk(HALF);
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(12);
      txb[0] = 8'h98; txb[1] = 8'h04; txb[2] = 8'h3C;
      xfer(3, 1'b0);
      model_write(3);
      check("R10", {24'h0, regs[31:24]}, 32'h3C);
      check("R3", {31'h0, spi_mode}, 32'h1);

      // R1 R3: reset returns defaults and two-wire mode
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
      for (int a = 1; a <= 9; a++) exp_r[a] = DEF_V[a];
      check_bank("R1");
      check("R3", {31'h0, spi_mode}, 32'h0);
      check("R1", {31'h0, sdo_oe}, 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule